// File: doc/BRIEF.md
# Sequential Integer Power Unit

The unit raises an integer base to an integer exponent, one operation at a time, under a start/busy/done handshake. The base is `N_BITS` wide and the exponent `E_BITS` wide. Two flags state whether each operand is to be read as two's complement. The result has the width of the base and is the true power reduced modulo 2^N. A separate flag marks the one case whose value is indeterminate: a zero base with a negative exponent.

Operations with a zero exponent, a zero base, or a negative exponent are resolved by a classifier in the cycle that start is taken, and they complete with no iteration. All other operations run square-and-multiply over the exponent, one bit per clock, starting from the least significant bit. The run stops as soon as the exponent bits still to be scanned are all zero. The signedness of the result follows the base flag only. Because the result is truncated, signed and unsigned products share the same bit pattern.

Top module: `int_pow_unit`

## Requirements
- R1: An exponent of all zeros yields 1 with `undef_o` low, for every base including zero and for every flag setting. This rule takes precedence over all others.
- R2: A zero base with an exponent that is nonzero and not negative yields 0 with `undef_o` low. This includes an unsigned exponent whose top bit is set.
- R3: An exponent is negative when `exp_signed_i` is 1 and its top bit is 1. A negative exponent with a zero base drives `result_o` to 0 and sets `undef_o` to 1. Whenever `undef_o` is 1, `result_o` is 0.
- R4: A negative exponent with base value 1 yields 1.
- R5: A negative exponent with `base_signed_i`=1 and a base of all ones (-1) yields all ones when exponent bit 0 is 1, and 1 when that bit is 0.
- R6: A negative exponent with any other base yields 0. An all-ones base with `base_signed_i`=0 is a large positive value and therefore also yields 0.
- R7: For an exponent that is not negative, the result equals base^exp modulo 2^N. For example, at 8 bits 6^3 = 0xD8, (-3)^3 = 0xE5 and 15^14 = 0x21.
- R8: `done_o` rises one clock after start is taken for a case covered by R1 to R6. Otherwise `busy_o` is high and `done_o` rises k+2 clocks after start, where k is the index of the highest set exponent bit. `busy_o` never falls without `done_o`, and the two are never high together.
- R9: `start_i` is ignored while `busy_o` is high, and the operation in flight finishes unchanged.
- R10: Outside a run, `result_o` and `undef_o` hold their values until the next accepted start. `done_o` is high for a single cycle per completed operation.
- R11: While `rst_ni` is low, `busy_o`, `done_o`, `undef_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation; taken only when not busy |
| base_i | input | N_BITS | Base operand |
| exp_i | input | E_BITS | Exponent operand |
| base_signed_i | input | 1 | Base is two's complement |
| exp_signed_i | input | 1 | Exponent is two's complement |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | N_BITS | Power modulo 2^N, held until the next accepted start |
| undef_o | output | 1 | Indeterminate result (zero base, negative exponent) |

## Verification
Two events can fall in the same cycle: the last iteration of a run and a new start request. The bench drives start during the final busy cycle of a nine-cycle run. It then expects that request to be ignored, with the run's own result appearing on `done_o`. The bench holds start high into the done cycle. That request must be accepted, producing a fresh one-cycle special result directly behind the first completion. A second case provokes a start in mid-run and checks that neither the result nor the latency changes.

// File: rtl/pow_pkg.sv
package pow_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pow_state_e;
endpackage

// File: rtl/pow_classify.sv
module pow_classify #(
  parameter int N_BITS = 8,
  parameter int E_BITS = 8
) (
  input  logic [N_BITS-1:0] base_i,
  input  logic [E_BITS-1:0] exp_i,
  input  logic              base_signed_i,
  input  logic              exp_signed_i,
  output logic              special_o,
  output logic [N_BITS-1:0] sp_result_o,
  output logic              sp_undef_o
);
  localparam logic [N_BITS-1:0] ONE = N_BITS'(1);

  logic exp_zero, exp_neg, base_zero, base_one, base_neg_one;

  assign exp_zero     = (exp_i == '0);
  assign exp_neg      = exp_signed_i & exp_i[E_BITS-1];
  assign base_zero    = (base_i == '0);
  assign base_one     = (base_i == ONE);
  assign base_neg_one = base_signed_i & (&base_i);

  always_comb begin
    special_o   = 1'b1;
    sp_result_o = '0;
    sp_undef_o  = 1'b0;
    if (exp_zero) begin
      sp_result_o = ONE;
    end else if (exp_neg) begin
      if (base_zero)         sp_undef_o  = 1'b1;
      else if (base_one)     sp_result_o = ONE;
      else if (base_neg_one) sp_result_o = exp_i[0] ? '1 : ONE;
    end else if (!base_zero) begin
      special_o = 1'b0;
    end
  end
endmodule

// File: rtl/pow_step.sv
module pow_step #(
  parameter int N_BITS = 8,
  parameter int E_BITS = 8
) (
  input  logic [N_BITS-1:0] acc_i,
  input  logic [N_BITS-1:0] sq_i,
  input  logic [E_BITS-1:0] exp_i,
  output logic [N_BITS-1:0] acc_o,
  output logic [N_BITS-1:0] sq_o,
  output logic [E_BITS-1:0] exp_o,
  output logic              last_o
);
  logic [N_BITS-1:0] mul_acc, mul_sq;

  // low half of the product only: modulo 2^N is all that is kept
  assign mul_acc = acc_i * sq_i;
  assign mul_sq  = sq_i * sq_i;
  assign acc_o   = exp_i[0] ? mul_acc : acc_i;
  assign sq_o    = mul_sq;
  assign exp_o   = exp_i >> 1;
  assign last_o  = (exp_o == '0);
endmodule

// File: rtl/int_pow_unit.sv
module int_pow_unit #(
  parameter int N_BITS = 8,
  parameter int E_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_BITS-1:0] base_i,
  input  logic [E_BITS-1:0] exp_i,
  input  logic              base_signed_i,
  input  logic              exp_signed_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [N_BITS-1:0] result_o,
  output logic              undef_o
);
  import pow_pkg::*;

  pow_state_e        state_q;
  logic [N_BITS-1:0] acc_q, sq_q, result_q;
  logic [E_BITS-1:0] exp_q;
  logic              done_q, undef_q;

  logic              special;
  logic [N_BITS-1:0] sp_result;
  logic              sp_undef;
  logic [N_BITS-1:0] acc_nxt, sq_nxt;
  logic [E_BITS-1:0] exp_nxt;
  logic              last;

  pow_classify #(.N_BITS(N_BITS), .E_BITS(E_BITS)) u_classify (
    .base_i       (base_i),
    .exp_i        (exp_i),
    .base_signed_i(base_signed_i),
    .exp_signed_i (exp_signed_i),
    .special_o    (special),
    .sp_result_o  (sp_result),
    .sp_undef_o   (sp_undef)
  );

  pow_step #(.N_BITS(N_BITS), .E_BITS(E_BITS)) u_step (
    .acc_i (acc_q),
    .sq_i  (sq_q),
    .exp_i (exp_q),
    .acc_o (acc_nxt),
    .sq_o  (sq_nxt),
    .exp_o (exp_nxt),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acc_q    <= '0;
      sq_q     <= '0;
      exp_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      undef_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (special) begin
              result_q <= sp_result;
              undef_q  <= sp_undef;
              done_q   <= 1'b1;
            end else begin
              acc_q   <= N_BITS'(1);
              sq_q    <= base_i;
              exp_q   <= exp_i;
              undef_q <= 1'b0;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          acc_q <= acc_nxt;
          sq_q  <= sq_nxt;
          exp_q <= exp_nxt;
          if (last) begin
            result_q <= acc_nxt;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign undef_o  = undef_q;
endmodule

// File: rtl/int_pow_unit_chk.sv
module int_pow_unit_chk #(
  parameter int N_BITS = 8,
  parameter int E_BITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [N_BITS-1:0] base_i,
  input logic [E_BITS-1:0] exp_i,
  input logic              base_signed_i,
  input logic              exp_signed_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [N_BITS-1:0] result_o,
  input logic              undef_o
);
  AST_ZERO_EXP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && exp_i == '0) |=> (done_o && result_o == N_BITS'(1) && !undef_o)); // R1

  AST_UNDEF_IMPLIES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == '0)); // R3

  AST_NEG_ONE_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && exp_signed_i && exp_i[E_BITS-1] && base_signed_i && (&base_i))
    |=> (done_o && result_o == (exp_i[0] ? {N_BITS{1'b1}} : N_BITS'(1)))); // R5

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o)); // R8

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(result_o) && $stable(undef_o) && !done_o)); // R10
endmodule

bind int_pow_unit int_pow_unit_chk #(.N_BITS(N_BITS), .E_BITS(E_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .base_i       (base_i),
  .exp_i        (exp_i),
  .base_signed_i(base_signed_i),
  .exp_signed_i (exp_signed_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o),
  .undef_o      (undef_o)
);

// File: tb/sim_int_pow_unit.sv
module sim_int_pow_unit;
  localparam int NB = 8;
  localparam int EB = 8;

  typedef struct packed {
    logic [7:0] b;
    logic [7:0] e;
    logic       bs;
    logic       es;
    logic [7:0] r;
    logic       u;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 8'd1},  // R1 zero^0
    '{8'h05, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 8'd1},  // R1
    '{8'h00, 8'h00, 1'b0, 1'b1, 8'h01, 1'b0, 8'd1},  // R1 precedence
    '{8'h00, 8'h03, 1'b0, 1'b0, 8'h00, 1'b0, 8'd2},  // R2
    '{8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 1'b0, 8'd2},  // R2 unsigned top bit
    '{8'h00, 8'h80, 1'b0, 1'b1, 8'h00, 1'b1, 8'd3},  // R3 undefined
    '{8'h00, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b1, 8'd3},  // R3
    '{8'h01, 8'hFD, 1'b1, 1'b1, 8'h01, 1'b0, 8'd4},  // R4
    '{8'h01, 8'h80, 1'b0, 1'b1, 8'h01, 1'b0, 8'd4},  // R4
    '{8'hFF, 8'hFD, 1'b1, 1'b1, 8'hFF, 1'b0, 8'd5},  // R5 odd
    '{8'hFF, 8'hFE, 1'b1, 1'b1, 8'h01, 1'b0, 8'd5},  // R5 even
    '{8'hFF, 8'hFD, 1'b0, 1'b1, 8'h00, 1'b0, 8'd6},  // R6 unsigned all-ones
    '{8'h03, 8'hFD, 1'b1, 1'b1, 8'h00, 1'b0, 8'd6},  // R6
    '{8'h06, 8'h03, 1'b0, 1'b0, 8'hD8, 1'b0, 8'd7},  // R7
    '{8'hFD, 8'h03, 1'b1, 1'b0, 8'hE5, 1'b0, 8'd7},  // R7 signed base
    '{8'h03, 8'h07, 1'b0, 1'b0, 8'h8B, 1'b0, 8'd7},  // R7
    '{8'h0F, 8'h0E, 1'b0, 1'b0, 8'h21, 1'b0, 8'd7},  // R7
    '{8'h03, 8'h83, 1'b1, 1'b0, 8'h1B, 1'b0, 8'd7},  // R7 full scan
    '{8'h02, 8'h07, 1'b0, 1'b0, 8'h80, 1'b0, 8'd7},  // R7
    '{8'h02, 8'h08, 1'b0, 1'b0, 8'h00, 1'b0, 8'd7},  // R7 truncated away
    '{8'hFF, 8'h02, 1'b0, 1'b0, 8'h01, 1'b0, 8'd7},  // R7
    '{8'h03, 8'h03, 1'b0, 1'b1, 8'h1B, 1'b0, 8'd7}   // R7 signed positive exp
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NB-1:0] base = '0;
  logic [EB-1:0] expv = '0;
  logic          bs = 1'b0;
  logic          es = 1'b0;
  logic          busy, done, undef;
  logic [NB-1:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  int_pow_unit #(.N_BITS(NB), .E_BITS(EB)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .base_i       (base),
    .exp_i        (expv),
    .base_signed_i(bs),
    .exp_signed_i (es),
    .busy_o       (busy),
    .done_o       (done),
    .result_o     (result),
    .undef_o      (undef)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input longint act, input longint expd);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, expd);
    end
  endtask

  function automatic int exp_latency(input logic [7:0] b, input logic [7:0] e, input logic s);
    int k = 0;
    if (e == 0 || (s && e[7]) || b == 0) return 1;
    for (int i = 0; i < 8; i++) if (e[i]) k = i;
    return k + 2;
  endfunction

  task automatic run_op(input logic [7:0] b, input logic [7:0] e, input logic sb,
                        input logic se, input logic [7:0] r, input logic u, input int req);
    int lat = 1;
    @(negedge clk);
    base = b; expv = e; bs = sb; es = se; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    check(result == r, req, "result", result, r);
    check(undef == u, req, "undef", undef, u);
    check(lat == exp_latency(b, e, se), 8, "latency", lat, exp_latency(b, e, se));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !undef && result == 0, 11, "reset state",
          {busy, done, undef, result}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].b, VECS[i].e, VECS[i].bs, VECS[i].es, VECS[i].r, VECS[i].u,
             int'(VECS[i].req));

    // R9: start mid-run is ignored
    @(negedge clk);
    base = 8'h03; expv = 8'h83; bs = 1'b1; es = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (2) begin @(negedge clk); lat++; end
    base = 8'h02; expv = 8'h00; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check(result == 8'h1B, 9, "result after mid-run start", result, 8'h1B);
    check(lat == 9, 9, "latency after mid-run start", lat, 9);
    @(negedge clk);
    check(!done && !busy, 9, "no extra op", {done, busy}, 0);

    // R9/R10: start in final busy cycle ignored, start in done cycle taken
    base = 8'h03; expv = 8'h83; bs = 1'b1; es = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    check(busy && !done, 8, "final busy cycle", {busy, done}, 2);
    base = 8'h05; expv = 8'h00; start = 1'b1;
    @(negedge clk);
    check(done && result == 8'h1B, 9, "start on last busy cycle ignored", result, 8'h1B);
    @(negedge clk);
    start = 1'b0;
    check(done && result == 8'h01, 10, "start on done cycle taken", result, 8'h01);

    // R10 hold with no start
    base = 8'h07; expv = 8'h05; bs = 1'b0; es = 1'b0;
    repeat (5) @(negedge clk);
    check(result == 8'h01 && !done && !busy, 10, "hold without start", result, 8'h01);

    // R10: undef held; R11: reset clears it and aborts a run
    run_op(8'h00, 8'h90, 1'b0, 1'b1, 8'h00, 1'b1, 3);
    repeat (3) @(negedge clk);
    check(undef == 1'b1, 10, "undef held", undef, 1);
    base = 8'h03; expv = 8'h83; bs = 1'b0; es = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !undef && result == 0, 11, "reset mid-run",
          {busy, done, undef, result}, 0);
    rst_n = 1'b1;
    run_op(8'h06, 8'h03, 1'b0, 1'b0, 8'hD8, 1'b0, 7);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule